// File: doc/BRIEF.md
# Video Field DMA Program Sequencer

This block runs a small DMA program held in memory. It fetches two-word instructions through a simple read port. Each instruction is a control word followed by an address word. The block can stall until a field sync of a chosen parity arrives, and it can branch to another program location. Line instructions become burst write requests for a downstream write engine. A scan line that spans several memory chunks is written as a chain of fragments. The first fragment is a line-start. Each later fragment is an in-line instruction, and its offset field gives the number of line bytes already moved.

Software writes the program, places a base address on the start port and pulses start. A typical program ends each field with a jump back to its own sync instruction. The engine then idles in the sync wait between fields. An interrupt pulse marks any instruction whose interrupt bit is set. A malformed control word raises a sticky error flag and parks the engine until the next start.

Top module: `fld_dma_seq`

## Requirements
- R1: After reset, prog_req_o, wr_valid_o, irq_o and err_o are low, and no fetch is issued until start_i is pulsed.
- R2: A start fetches the control word at base_addr_i and then the address word at base+4. Control word layout: bit 31 must be 1; bits 30:28 hold the opcode (1 jump, 2 sync-odd, 3 sync-even, 4 line-start, 5 in-line); bit 27 requests an interrupt; for line opcodes bits 26:24 hold the data type, bits 23:12 the byte offset within the line and bits 11:0 the byte count.
- R3: A line-start with a nonzero count raises wr_valid_o. The address word appears on wr_addr_o, and the count, offset and type fields appear on their outputs. All of them stay stable until wr_ready_i is sampled high.
- R4: For a split line, the type-7 line-start and each following in-line instruction produce one request per fragment, in program order. Each request carries its own offset, count, type and address.
- R5: After a line or sync instruction completes, the next control fetch is at the previous control address plus 8. No fetch is issued while a write request is pending.
- R6: A line instruction with count 0 completes without raising wr_valid_o.
- R7: A jump makes the next control fetch come from its address word.
- R8: Sync-odd completes only on an fsync_i pulse with fsync_odd_i high. Even-parity pulses are ignored.
- R9: Sync-even completes only on an fsync_i pulse with fsync_odd_i low. Odd-parity pulses are ignored.
- R10: irq_o pulses for one cycle when an instruction with bit 27 set completes, and only then.
- R11: A control word with bit 31 clear, or with opcode 0, 6 or 7, sets err_o. The flag stays set. After that no fetch and no write request is issued.
- R12: start_i is honoured when the engine is idle, halted on an error or waiting for a sync. It clears err_o and restarts fetching at the new base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| base_addr_i | input | AW | Program base address, sampled with start |
| prog_req_o | output | 1 | Program word read request, held until data returns |
| prog_addr_o | output | AW | Program word byte address |
| prog_rvalid_i | input | 1 | Read data valid, ends the read |
| prog_rdata_i | input | 32 | Program word |
| fsync_i | input | 1 | Field sync pulse |
| fsync_odd_i | input | 1 | Field parity with the sync pulse, 1 = odd |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | 32 | Destination address |
| wr_count_o | output | 12 | Byte count |
| wr_offset_o | output | 12 | Byte offset of the fragment inside the line |
| wr_type_o | output | 3 | Data type |
| irq_o | output | 1 | Interrupt pulse |
| err_o | output | 1 | Sticky invalid-instruction flag |

## Verification
The bound checker checks these rules on every cycle:
- A pending write request holds its fields until it is accepted.
- No fetch overlaps a write request.
- A zero count never reaches the write port.
- The interrupt is a single-cycle pulse.
- The error flag stays set, keeps the engine quiet, and is cleared by start.

Some behaviour can only be shown by the bench's scenarios, through its logs of fetch addresses and accepted requests:
- The fetch order through a program, including the +8 step and jump targets.
- The parity filtering of the sync waits.
- The field contents of each fragment of a split line.
- The restart at a new base from a sync wait.

// File: rtl/fds_pkg.sv
package fds_pkg;
   localparam int WORD_W  = 32;
   localparam int FIELD_W = 12;
   localparam int TYPE_W  = 3;
   localparam int STEP_B  = 8;

   localparam logic [2:0] OPC_JUMP       = 3'd1;
   localparam logic [2:0] OPC_SYNC_ODD   = 3'd2;
   localparam logic [2:0] OPC_SYNC_EVEN  = 3'd3;
   localparam logic [2:0] OPC_LINE_FIRST = 3'd4;
   localparam logic [2:0] OPC_LINE_NEXT  = 3'd5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH_CTL, ST_FETCH_ADR, ST_EXEC,
      ST_WAIT_SYNC, ST_WRITE, ST_HALT
   } seq_state_e;

   typedef struct packed {
      logic               legal;
      logic               is_jump;
      logic               is_sync;
      logic               want_odd;
      logic               is_line;
      logic               irq;
      logic [TYPE_W-1:0]  dtype;
      logic [FIELD_W-1:0] ofs;
      logic [FIELD_W-1:0] cnt;
   } insn_t;
endpackage

// File: rtl/fds_decode.sv
module fds_decode
   import fds_pkg::*;
(
   input  logic [WORD_W-1:0] ctl_word,
   output insn_t             insn
);
   logic [2:0] opc;

   always_comb begin
      opc          = ctl_word[30:28];
      insn         = '0;
      insn.irq     = ctl_word[27];
      insn.dtype   = ctl_word[24 +: TYPE_W];
      insn.ofs     = ctl_word[12 +: FIELD_W];
      insn.cnt     = ctl_word[0 +: FIELD_W];
      case (opc)
         OPC_JUMP:       insn.is_jump = 1'b1;
         OPC_SYNC_ODD:   begin insn.is_sync = 1'b1; insn.want_odd = 1'b1; end
         OPC_SYNC_EVEN:  insn.is_sync = 1'b1;
         OPC_LINE_FIRST,
         OPC_LINE_NEXT:  insn.is_line = 1'b1;
         default:        ;
      endcase
      insn.legal = ctl_word[31] & (insn.is_jump | insn.is_sync | insn.is_line);
   end
endmodule

// File: rtl/fds_pc.sv
module fds_pc #(
   parameter int AW   = 32,
   parameter int STEP = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] pc
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n)    pc <= '0;
      else if (load) pc <= load_val;
      else if (step) pc <= pc + STEP_V;
   end
endmodule

// File: rtl/fld_dma_seq.sv
module fld_dma_seq
   import fds_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [AW-1:0]      base_addr_i,
   output logic               prog_req_o,
   output logic [AW-1:0]      prog_addr_o,
   input  logic               prog_rvalid_i,
   input  logic [WORD_W-1:0]  prog_rdata_i,
   input  logic               fsync_i,
   input  logic               fsync_odd_i,
   output logic               wr_valid_o,
   input  logic               wr_ready_i,
   output logic [WORD_W-1:0]  wr_addr_o,
   output logic [FIELD_W-1:0] wr_count_o,
   output logic [FIELD_W-1:0] wr_offset_o,
   output logic [TYPE_W-1:0]  wr_type_o,
   output logic               irq_o,
   output logic               err_o
);
   localparam logic [AW-1:0] WORD_STEP = AW'(4);

   generate
      if (AW < 4 || AW > 64) begin : g_bad_aw
         $error("fld_dma_seq: AW must lie in 4..64");
      end
   endgenerate

   seq_state_e        state;
   logic [WORD_W-1:0] ctl_q, adr_q;
   logic              irq_q, err_q;
   insn_t             insn;
   logic [AW-1:0]     pc, jmp_ext, pc_val;
   logic              restart, sync_hit, zero_line, pc_load, pc_step;

   fds_decode u_dec (.ctl_word(ctl_q), .insn(insn));

   generate
      if (AW > WORD_W) begin : g_wide
         assign jmp_ext = {{(AW-WORD_W){1'b0}}, adr_q};
      end else begin : g_narrow
         assign jmp_ext = adr_q[AW-1:0];
      end
   endgenerate

   assign restart   = start_i & (state == ST_IDLE || state == ST_HALT || state == ST_WAIT_SYNC);
   assign sync_hit  = (state == ST_WAIT_SYNC) & fsync_i & (fsync_odd_i == insn.want_odd);
   assign zero_line = (state == ST_EXEC) & insn.legal & insn.is_line & (insn.cnt == '0);
   assign pc_load   = restart | ((state == ST_EXEC) & insn.legal & insn.is_jump);
   assign pc_val    = restart ? base_addr_i : jmp_ext;
   assign pc_step   = ~restart & (sync_hit | zero_line | ((state == ST_WRITE) & wr_ready_i));

   fds_pc #(.AW(AW), .STEP(STEP_B)) u_pc (
      .clk(clk), .rst_n(rst_n), .load(pc_load), .load_val(pc_val),
      .step(pc_step), .pc(pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ctl_q <= '0;
         adr_q <= '0;
         irq_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (restart) begin
            state <= ST_FETCH_CTL;
            err_q <= 1'b0;
         end else begin
            case (state)
               ST_FETCH_CTL: if (prog_rvalid_i) begin
                  ctl_q <= prog_rdata_i;
                  state <= ST_FETCH_ADR;
               end
               ST_FETCH_ADR: if (prog_rvalid_i) begin
                  adr_q <= prog_rdata_i;
                  state <= ST_EXEC;
               end
               ST_EXEC: begin
                  if (!insn.legal) begin
                     err_q <= 1'b1;
                     state <= ST_HALT;
                  end else if (insn.is_jump || zero_line) begin
                     irq_q <= insn.irq;
                     state <= ST_FETCH_CTL;
                  end else if (insn.is_sync) begin
                     state <= ST_WAIT_SYNC;
                  end else begin
                     state <= ST_WRITE;
                  end
               end
               ST_WAIT_SYNC: if (sync_hit) begin
                  irq_q <= insn.irq;
                  state <= ST_FETCH_CTL;
               end
               ST_WRITE: if (wr_ready_i) begin
                  irq_q <= insn.irq;
                  state <= ST_FETCH_CTL;
               end
               default: ;
            endcase
         end
      end
   end

   assign prog_req_o  = (state == ST_FETCH_CTL) | (state == ST_FETCH_ADR);
   assign prog_addr_o = (state == ST_FETCH_ADR) ? pc + WORD_STEP : pc;
   assign wr_valid_o  = (state == ST_WRITE);
   assign wr_addr_o   = adr_q;
   assign wr_count_o  = insn.cnt;
   assign wr_offset_o = insn.ofs;
   assign wr_type_o   = insn.dtype;
   assign irq_o       = irq_q;
   assign err_o       = err_q;
endmodule

// File: rtl/fds_checker.sv
module fds_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        prog_req_o,
   input logic        wr_valid_o,
   input logic        wr_ready_i,
   input logic [31:0] wr_addr_o,
   input logic [11:0] wr_count_o,
   input logic [11:0] wr_offset_o,
   input logic [2:0]  wr_type_o,
   input logic        irq_o,
   input logic        err_o
);
   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) &&
      $stable(wr_count_o) && $stable(wr_offset_o) && $stable(wr_type_o));

   a_r5_no_fetch_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> !prog_req_o);

   a_r6_nonzero_count: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> wr_count_o != 12'd0);

   a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !prog_req_o && !wr_valid_o);

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !start_i |=> err_o);

   a_r12_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && start_i |=> !err_o);
endmodule

bind fld_dma_seq fds_checker u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_req_o(prog_req_o),
   .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
   .wr_count_o(wr_count_o), .wr_offset_o(wr_offset_o), .wr_type_o(wr_type_o),
   .irq_o(irq_o), .err_o(err_o)
);

// File: tb/fld_dma_seq_test.sv
`timescale 1ns/1ps
module fld_dma_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_addr_i = '0;
   logic        prog_req_o;
   logic [31:0] prog_addr_o;
   logic        prog_rvalid_i = 1'b0;
   logic [31:0] prog_rdata_i = '0;
   logic        fsync_i = 1'b0;
   logic        fsync_odd_i = 1'b0;
   logic        wr_valid_o;
   logic        wr_ready_i = 1'b0;
   logic [31:0] wr_addr_o;
   logic [11:0] wr_count_o, wr_offset_o;
   logic [2:0]  wr_type_o;
   logic        irq_o, err_o;

   int nchk = 0, nfail = 0, cyc = 0;
   logic [31:0] mem [0:255];
   logic [31:0] flog [0:1023];
   logic [31:0] wa [0:255];
   logic [11:0] wc [0:255], wo [0:255];
   logic [2:0]  wt [0:255];
   int fn = 0, wn = 0, inum = 0;

   always #2.5 clk = ~clk;

   fld_dma_seq #(.AW(32)) uut (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (prog_req_o && !prog_rvalid_i) begin
         prog_rvalid_i <= 1'b1;
         prog_rdata_i  <= mem[prog_addr_o[9:2]];
         flog[fn]      <= prog_addr_o;
         fn            <= fn + 1;
      end else begin
         prog_rvalid_i <= 1'b0;
      end
      wr_ready_i <= wr_valid_o && !wr_ready_i && (cyc[1:0] == 2'd3);
      if (wr_valid_o && wr_ready_i) begin
         wa[wn] <= wr_addr_o; wc[wn] <= wr_count_o;
         wo[wn] <= wr_offset_o; wt[wn] <= wr_type_o;
         wn <= wn + 1;
      end
      if (irq_o) inum <= inum + 1;
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] cw(logic [2:0] op, logic irq, logic [2:0] typ,
                                      logic [11:0] ofs, logic [11:0] cnt);
      return {1'b1, op, irq, typ, ofs, cnt};
   endfunction

   task automatic put(logic [31:0] a, logic [31:0] c, logic [31:0] d);
      mem[a[9:2]]     = c;
      mem[a[9:2] + 1] = d;
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic kick(logic [31:0] base);
      @(negedge clk); start_i = 1'b1; base_addr_i = base;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic sync_pulse(logic odd);
      @(negedge clk); fsync_i = 1'b1; fsync_odd_i = odd;
      @(negedge clk); fsync_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "prog_req", prog_req_o, 0);
      chk("R1", "wr_valid", wr_valid_o, 0);
      chk("R1", "irq", irq_o, 0);
      chk("R1", "err", err_o, 0);
      wait_n(10);
      chk("R1", "fetches before start", fn, 0);
   endtask

   task automatic t_basic;
      int f0, w0, i0;
      logic [31:0] exp_f [12];
      put(32'h40, cw(3'd2, 0, 0, 0, 0), 0);
      put(32'h48, cw(3'd4, 1, 3'd2, 0, 12'd100), 32'h1000);
      put(32'h50, cw(3'd4, 0, 3'd1, 0, 12'd0), 32'h1800);
      put(32'h58, cw(3'd4, 0, 3'd3, 0, 12'd200), 32'h2000);
      put(32'h60, cw(3'd1, 0, 0, 0, 0), 32'h40);
      f0 = fn; w0 = wn; i0 = inum;
      kick(32'h40);
      wait_n(20);
      chk("R2", "first control fetch", flog[f0], 32'h40);
      chk("R2", "first address fetch", flog[f0+1], 32'h44);
      sync_pulse(1'b0);
      wait_n(20);
      chk("R8", "writes after even sync", wn - w0, 0);
      sync_pulse(1'b1);
      wait_n(100);
      chk("R6", "write count (zero line skipped)", wn - w0, 2);
      chk("R3", "addr", wa[w0], 32'h1000);
      chk("R3", "count", wc[w0], 100);
      chk("R3", "offset", wo[w0], 0);
      chk("R3", "type", wt[w0], 2);
      chk("R6", "second write addr", wa[w0+1], 32'h2000);
      chk("R6", "second write count", wc[w0+1], 200);
      chk("R10", "irq pulses", inum - i0, 1);
      exp_f = '{32'h40, 32'h44, 32'h48, 32'h4C, 32'h50, 32'h54,
                32'h58, 32'h5C, 32'h60, 32'h64, 32'h40, 32'h44};
      for (int k = 0; k < 12; k++)
         chk(k < 10 ? "R5" : "R7", "fetch order", flog[f0+k], exp_f[k]);
      chk("R7", "fetches parked at sync", fn - f0, 12);
   endtask

   task automatic t_split;
      int w0, i0;
      put(32'h100, cw(3'd3, 0, 0, 0, 0), 0);
      put(32'h108, cw(3'd4, 0, 3'd7, 12'd0, 12'd30), 32'h7F0);
      put(32'h110, cw(3'd5, 0, 3'd0, 12'd30, 12'd50), 32'h5000);
      put(32'h118, cw(3'd5, 1, 3'd0, 12'd80, 12'd20), 32'h6000);
      put(32'h120, cw(3'd1, 0, 0, 0, 0), 32'h100);
      w0 = wn; i0 = inum;
      kick(32'h100);
      wait_n(20);
      sync_pulse(1'b1);
      wait_n(20);
      chk("R9", "writes after odd sync", wn - w0, 0);
      sync_pulse(1'b0);
      wait_n(100);
      chk("R4", "fragments", wn - w0, 3);
      chk("R4", "frag0 type", wt[w0], 7);
      chk("R4", "frag0 addr", wa[w0], 32'h7F0);
      chk("R4", "frag1 offset", wo[w0+1], 30);
      chk("R4", "frag1 count", wc[w0+1], 50);
      chk("R4", "frag1 addr", wa[w0+1], 32'h5000);
      chk("R4", "frag2 offset", wo[w0+2], 80);
      chk("R4", "frag2 addr", wa[w0+2], 32'h6000);
      chk("R10", "irq pulses split", inum - i0, 1);
   endtask

   task automatic t_invalid;
      int w0, f1, i0;
      logic [2:0] bad [3];
      put(32'h200, cw(3'd4, 0, 0, 0, 12'd10), 32'h9000);
      put(32'h208, 32'h4000_0000, 0);
      w0 = wn; i0 = inum;
      kick(32'h200);
      wait_n(50);
      chk("R11", "err after clear bit31", err_o, 1);
      chk("R11", "writes before error", wn - w0, 1);
      f1 = fn;
      wait_n(30);
      chk("R11", "no fetch while halted", fn - f1, 0);
      chk("R11", "err sticky", err_o, 1);
      chk("R11", "wr_valid while halted", wr_valid_o, 0);
      chk("R10", "no irq", inum - i0, 0);
      bad = '{3'd0, 3'd6, 3'd7};
      for (int k = 0; k < 3; k++) begin
         put(32'h240, cw(bad[k], 0, 0, 0, 12'd5), 32'h9100);
         kick(32'h240);
         chk("R12", "err cleared by start", err_o, 0);
         wait_n(30);
         chk("R11", "err on bad opcode", err_o, 1);
      end
   endtask

   task automatic t_restart;
      int w0, f0;
      put(32'h280, cw(3'd2, 0, 0, 0, 0), 0);
      put(32'h288, cw(3'd1, 0, 0, 0, 0), 32'h280);
      put(32'h2C0, cw(3'd3, 0, 0, 0, 0), 0);
      put(32'h2C8, cw(3'd4, 0, 3'd5, 0, 12'd64), 32'hA000);
      put(32'h2D0, cw(3'd1, 0, 0, 0, 0), 32'h2C0);
      kick(32'h280);
      wait_n(20);
      w0 = wn; f0 = fn;
      kick(32'h2C0);
      wait_n(20);
      chk("R12", "fetch at new base", flog[f0], 32'h2C0);
      sync_pulse(1'b0);
      wait_n(60);
      chk("R12", "writes from new program", wn - w0, 1);
      chk("R12", "write addr new program", wa[w0], 32'hA000);
      chk("R12", "write type new program", wt[w0], 5);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      wait_n(4);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_split;
      t_invalid;
      t_restart;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule